// File: doc/BRIEF.md
# Bus Clock Divisor Pair Search Engine

This block finds the two timing counts that set a two-wire serial bus clock: a sample count from 1 to 8 and a step count from 1 up to a limit that depends on the speed mode. The bus period is the source clock period times twice the product of the two counts. The block accepts a source clock frequency and a wanted bus frequency, both in hertz. It then searches for the pair whose product is the smallest one at or above the needed division ratio. That pair gives the fastest bus rate that does not go above the request.

A run begins with a one-cycle `start` while the block is idle. All arithmetic is done by one shared divider that produces one quotient bit per clock. Each run uses a fixed number of divisions: one for the ratio, one for each sample count it examines, and one for the final range check. When the run ends, `done` pulses for one cycle. The two counts then appear as minus-one values ready for a register, together with a flag that says the source clock is too fast for the request. These results hold until the next run finishes. `clk_src_hz` must be at least 2.

Top module: `i2c_divpair_search`

## Requirements
- R1: After reset, `busy`, `done`, `too_fast`, `sample_m1` and `step_m1` are all 0.
- R2: A `target_hz` above 3,400,000 is treated as exactly 3,400,000 in every later step, including the range check.
- R3: The step count limit is 8 when the effective target is strictly above 400,000 Hz. Otherwise it is 64. A target of exactly 400,000 uses 64.
- R4: The ratio is ceil(floor(`clk_src_hz`/2) / target). Sample counts s = 1..8 are tried in rising order, with step = ceil(ratio/s). A candidate whose step is within the limit replaces the current best only if step*s is strictly smaller. Outputs are `sample_m1` = best sample − 1 and `step_m1` = best step − 1.
- R5: Before the search, the best pair is sample 8 with step equal to the limit. If no candidate replaces it, the outputs are 7 and limit − 1.
- R6: `too_fast` is 1 exactly when floor(`clk_src_hz` / (2*sample*step)) for the chosen pair is greater than the effective target.
- R7: The search stops right after a replacement whose product equals the ratio. `busy` stays high for exactly (k+2)*(FREQ_W+2) cycles, where k is the number of sample counts examined (FREQ_W = 32 by default).
- R8: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after a run. The outputs do not change until the next run completes, even if the input ports change.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress keeps its captured inputs and its length.
- R10: A `target_hz` of 0 is treated as 1 Hz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; taken only while idle |
| clk_src_hz | input | 32 | Source clock frequency in Hz (at least 2) |
| target_hz | input | 32 | Wanted bus frequency in Hz |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle pulse when results are updated |
| sample_m1 | output | 3 | Chosen sample count minus one |
| step_m1 | output | 6 | Chosen step count minus one |
| too_fast | output | 1 | The source clock is too fast to reach the target with any allowed pair |

## Verification
The early stop leaves the result unchanged, because any exact hit is already the smallest possible product. The only way to see it at the ports is the length of the busy window. The bench therefore picks operand pairs whose ratio divides exactly at sample 1 or sample 3, and pairs that have no exact hit. It checks that the busy cycle count matches (k+2) divisions for each. A second case that is hard to reach is the fallback pair with the error flag set. For this, the bench asks for 400,001 Hz, where the limit of 8 rejects every candidate, and for 100 Hz from a 200 MHz source.

// File: rtl/i2c_divpair_pkg.sv
package i2c_divpair_pkg;

  // Controller phases; each *_GO phase launches one division.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RATIO_GO,
    ST_RATIO_WAIT,
    ST_STEP_GO,
    ST_STEP_WAIT,
    ST_CHK_GO,
    ST_CHK_WAIT
  } phase_t;

  localparam int unsigned DEF_FREQ_W       = 32;
  localparam int unsigned DEF_SAMPLE_MAX   = 8;
  localparam int unsigned DEF_STEP_MAX_HS  = 8;
  localparam int unsigned DEF_STEP_MAX_STD = 64;
  localparam int unsigned DEF_RATE_CAP_HZ  = 3400000;
  localparam int unsigned DEF_FAST_MAX_HZ  = 400000;

endpackage

// File: rtl/divpair_mode.sv
// Clamps the requested rate and chooses the step limit for its speed class.
module divpair_mode #(
  parameter int unsigned FREQ_W       = 32,
  parameter int unsigned STEP_MAX_HS  = 8,
  parameter int unsigned STEP_MAX_STD = 64,
  parameter int unsigned RATE_CAP_HZ  = 3400000,
  parameter int unsigned FAST_MAX_HZ  = 400000,
  parameter int unsigned STEPF_W      = 7
) (
  input  logic [FREQ_W-1:0]  target_hz,
  output logic [FREQ_W-1:0]  target_eff,
  output logic [STEPF_W-1:0] step_lim
);

  always_comb begin
    if (target_hz == '0) begin
      target_eff = FREQ_W'(1);
    end else if (target_hz > FREQ_W'(RATE_CAP_HZ)) begin
      target_eff = FREQ_W'(RATE_CAP_HZ);
    end else begin
      target_eff = target_hz;
    end
    step_lim = (target_eff > FREQ_W'(FAST_MAX_HZ)) ? STEPF_W'(STEP_MAX_HS)
                                                   : STEPF_W'(STEP_MAX_STD);
  end

endmodule

// File: rtl/divpair_seqdiv.sv
// Restoring divider, one quotient bit per cycle, W cycles per division.
module divpair_seqdiv #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         rdy,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  div_q, div_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          rdy_q, rdy_n;
  logic          adv_en;

  logic [W:0]    rem_sh;
  logic [W-1:0]  diff;
  logic          take;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    take   = (rem_sh >= {1'b0, div_q});
    diff   = rem_sh[W-1:0] - div_q;

    quo_n  = quo_q;
    rem_n  = rem_q;
    div_n  = div_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    rdy_n  = 1'b0;
    if (go) begin
      quo_n = dividend;
      rem_n = '0;
      div_n = divisor;
      cnt_n = CW'(W);
      act_n = 1'b1;
    end else if (act_q) begin
      quo_n = {quo_q[W-2:0], take};
      rem_n = take ? diff : rem_sh[W-1:0];
      cnt_n = cnt_q - CW'(1);
      act_n = (cnt_q != CW'(1));
      rdy_n = (cnt_q == CW'(1));
    end
  end

  assign adv_en = go | act_q | rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (adv_en) begin
      quo_q <= quo_n;
      rem_q <= rem_n;
      div_q <= div_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
      rdy_q <= rdy_n;
    end
  end

  assign rdy = rdy_q;
  assign quo = quo_q;
  assign rem = rem_q;

  // R4: a finished division leaves a remainder below the divisor
  p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> (rem_q < div_q));

  // R7: the completion strobe lasts one cycle, so each division costs a fixed time
  p_rdy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);

endmodule

// File: rtl/divpair_cand.sv
// Rounds a quotient up and scores it as a candidate against the best pair.
module divpair_cand #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned STEPF_W = 7,
  parameter int unsigned PROD_W  = 36
) (
  input  logic [FREQ_W-1:0]  quo,
  input  logic [FREQ_W-1:0]  rem,
  input  logic [CNT_W-1:0]   smp,
  input  logic [FREQ_W-1:0]  ratio,
  input  logic [STEPF_W-1:0] lim,
  input  logic [PROD_W-1:0]  best_prod,
  output logic [FREQ_W-1:0]  q_up,
  output logic               better,
  output logic               exact
);

  logic              fits;
  logic [PROD_W-1:0] prod;

  always_comb begin
    q_up   = quo + FREQ_W'(rem != '0);
    fits   = (q_up <= FREQ_W'(lim));
    prod   = PROD_W'(q_up) * PROD_W'(smp);
    better = fits && (prod < best_prod);
    exact  = better && (prod == PROD_W'(ratio));
  end

endmodule

// File: rtl/i2c_divpair_search.sv
module i2c_divpair_search
  import i2c_divpair_pkg::*;
#(
  parameter int unsigned FREQ_W       = DEF_FREQ_W,
  parameter int unsigned SAMPLE_MAX   = DEF_SAMPLE_MAX,
  parameter int unsigned STEP_MAX_HS  = DEF_STEP_MAX_HS,
  parameter int unsigned STEP_MAX_STD = DEF_STEP_MAX_STD,
  parameter int unsigned RATE_CAP_HZ  = DEF_RATE_CAP_HZ,
  parameter int unsigned FAST_MAX_HZ  = DEF_FAST_MAX_HZ
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [FREQ_W-1:0]               clk_src_hz,
  input  logic [FREQ_W-1:0]               target_hz,
  output logic                            busy,
  output logic                            done,
  output logic [$clog2(SAMPLE_MAX)-1:0]   sample_m1,
  output logic [$clog2(STEP_MAX_STD)-1:0] step_m1,
  output logic                            too_fast
);

  localparam int unsigned SAMPLE_W = $clog2(SAMPLE_MAX);
  localparam int unsigned STEP_W   = $clog2(STEP_MAX_STD);
  localparam int unsigned CNT_W    = $clog2(SAMPLE_MAX + 1);
  localparam int unsigned STEPF_W  = $clog2(STEP_MAX_STD + 1);
  localparam int unsigned PROD_W   = FREQ_W + CNT_W;

  phase_t               phase_q, phase_n;
  logic [FREQ_W-1:0]    clk_q, clk_n;
  logic [FREQ_W-1:0]    tgt_q, tgt_n;
  logic [STEPF_W-1:0]   lim_q, lim_n;
  logic [FREQ_W-1:0]    ratio_q, ratio_n;
  logic [CNT_W-1:0]     smp_q, smp_n;
  logic [CNT_W-1:0]     bs_q, bs_n;
  logic [STEPF_W-1:0]   bst_q, bst_n;
  logic [SAMPLE_W-1:0]  smp_out_q, smp_out_n;
  logic [STEP_W-1:0]    stp_out_q, stp_out_n;
  logic                 err_q, err_n;
  logic                 done_q, done_n;
  logic                 run_en, res_en;

  logic [FREQ_W-1:0]    target_eff;
  logic [STEPF_W-1:0]   step_lim;
  logic                 div_go, div_rdy;
  logic [FREQ_W-1:0]    div_a, div_b, div_quo, div_rem;
  logic [FREQ_W-1:0]    q_up;
  logic                 cand_better, cand_exact;
  logic [PROD_W-1:0]    best_prod;

  divpair_mode #(
    .FREQ_W(FREQ_W), .STEP_MAX_HS(STEP_MAX_HS), .STEP_MAX_STD(STEP_MAX_STD),
    .RATE_CAP_HZ(RATE_CAP_HZ), .FAST_MAX_HZ(FAST_MAX_HZ), .STEPF_W(STEPF_W)
  ) u_mode (
    .target_hz (target_hz),
    .target_eff(target_eff),
    .step_lim  (step_lim)
  );

  divpair_seqdiv #(.W(FREQ_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .dividend(div_a),
    .divisor (div_b),
    .rdy     (div_rdy),
    .quo     (div_quo),
    .rem     (div_rem)
  );

  assign best_prod = PROD_W'(bs_q) * PROD_W'(bst_q);

  divpair_cand #(
    .FREQ_W(FREQ_W), .CNT_W(CNT_W), .STEPF_W(STEPF_W), .PROD_W(PROD_W)
  ) u_cand (
    .quo      (div_quo),
    .rem      (div_rem),
    .smp      (smp_q),
    .ratio    (ratio_q),
    .lim      (lim_q),
    .best_prod(best_prod),
    .q_up     (q_up),
    .better   (cand_better),
    .exact    (cand_exact)
  );

  // Operand selection for the shared divider
  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = '0;
    unique case (phase_q)
      ST_RATIO_GO: begin
        div_go = 1'b1;
        div_a  = clk_q >> 1;
        div_b  = tgt_q;
      end
      ST_STEP_GO: begin
        div_go = 1'b1;
        div_a  = ratio_q;
        div_b  = FREQ_W'(smp_q);
      end
      ST_CHK_GO: begin
        div_go = 1'b1;
        div_a  = clk_q;
        div_b  = (FREQ_W'(bs_q) * FREQ_W'(bst_q)) << 1;
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    phase_n   = phase_q;
    clk_n     = clk_q;
    tgt_n     = tgt_q;
    lim_n     = lim_q;
    ratio_n   = ratio_q;
    smp_n     = smp_q;
    bs_n      = bs_q;
    bst_n     = bst_q;
    smp_out_n = smp_out_q;
    stp_out_n = stp_out_q;
    err_n     = err_q;
    done_n    = 1'b0;
    res_en    = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (start) begin
          clk_n   = clk_src_hz;
          tgt_n   = target_eff;
          lim_n   = step_lim;
          smp_n   = CNT_W'(1);
          bs_n    = CNT_W'(SAMPLE_MAX);
          bst_n   = step_lim;
          phase_n = ST_RATIO_GO;
        end
      end
      ST_RATIO_GO: phase_n = ST_RATIO_WAIT;
      ST_RATIO_WAIT: begin
        if (div_rdy) begin
          ratio_n = q_up;
          phase_n = ST_STEP_GO;
        end
      end
      ST_STEP_GO: phase_n = ST_STEP_WAIT;
      ST_STEP_WAIT: begin
        if (div_rdy) begin
          if (cand_better) begin
            bs_n  = smp_q;
            bst_n = q_up[STEPF_W-1:0];
          end
          if (cand_exact || (smp_q == CNT_W'(SAMPLE_MAX))) begin
            phase_n = ST_CHK_GO;
          end else begin
            smp_n   = smp_q + CNT_W'(1);
            phase_n = ST_STEP_GO;
          end
        end
      end
      ST_CHK_GO: phase_n = ST_CHK_WAIT;
      ST_CHK_WAIT: begin
        if (div_rdy) begin
          res_en    = 1'b1;
          err_n     = (div_quo > tgt_q);
          smp_out_n = SAMPLE_W'(bs_q - CNT_W'(1));
          stp_out_n = STEP_W'(bst_q - STEPF_W'(1));
          done_n    = 1'b1;
          phase_n   = ST_IDLE;
        end
      end
      default: phase_n = ST_IDLE;
    endcase
  end

  assign run_en = (phase_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      clk_q   <= '0;
      tgt_q   <= '0;
      lim_q   <= '0;
      ratio_q <= '0;
      smp_q   <= '0;
      bs_q    <= '0;
      bst_q   <= '0;
    end else if (run_en) begin
      phase_q <= phase_n;
      clk_q   <= clk_n;
      tgt_q   <= tgt_n;
      lim_q   <= lim_n;
      ratio_q <= ratio_n;
      smp_q   <= smp_n;
      bs_q    <= bs_n;
      bst_q   <= bst_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_out_q <= '0;
      stp_out_q <= '0;
      err_q     <= 1'b0;
    end else if (res_en) begin
      smp_out_q <= smp_out_n;
      stp_out_q <= stp_out_n;
      err_q     <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
    end
  end

  assign busy      = (phase_q != ST_IDLE);
  assign done      = done_q;
  assign sample_m1 = smp_out_q;
  assign step_m1   = stp_out_q;
  assign too_fast  = err_q;

  // R8: completion is a single-cycle strobe
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: every end of a busy window is marked by done
  p_busy_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: results hold while idle without a start
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sample_m1) && $stable(step_m1) && $stable(too_fast)));

  // R9: captured operands cannot change during a run
  p_inputs_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(clk_q) && $stable(tgt_q) && $stable(lim_q)));

  // R3: the best step never exceeds the mode limit
  p_step_within_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bst_q <= lim_q);

  // R4: the sample count under test stays in 1..SAMPLE_MAX
  p_sample_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((smp_q >= CNT_W'(1)) && (smp_q <= CNT_W'(SAMPLE_MAX))));

  // R2: the captured target never exceeds the cap
  p_target_capped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tgt_q <= FREQ_W'(RATE_CAP_HZ)));

endmodule

// File: tb/tb_i2c_divpair_search.sv
module tb_i2c_divpair_search;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_CYC    = 34;   // FREQ_W + 2 cycles per division

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] clk_src_hz;
  logic [31:0] target_hz;
  logic        busy;
  logic        done;
  logic [2:0]  sample_m1;
  logic [5:0]  step_m1;
  logic        too_fast;

  i2c_divpair_search dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .clk_src_hz(clk_src_hz), .target_hz(target_hz),
    .busy(busy), .done(done), .sample_m1(sample_m1),
    .step_m1(step_m1), .too_fast(too_fast)
  );

  typedef struct packed {
    logic [31:0] smp;
    logic [31:0] stp;
    logic        err;
    logic [31:0] cyc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  int results_seen = 0;
  logic done_prev = 1'b0;
  bit   finished = 0;
  exp_t last_exp;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Independent model of the requirements (R2..R7, R10)
  function automatic exp_t model(input longint c, input longint tg);
    exp_t e;
    longint t, lim, ratio, bs, bst, stp, k;
    t = (tg > 3400000) ? 3400000 : tg;
    if (t == 0) t = 1;
    lim = (t > 400000) ? 8 : 64;
    ratio = ((c >> 1) + t - 1) / t;
    bs = 8; bst = lim; k = 0;
    for (int s = 1; s <= 8; s++) begin
      k = s;
      stp = (ratio + s - 1) / s;
      if (stp <= lim && stp * s < bs * bst) begin
        bs = s; bst = stp;
        if (stp * s == ratio) break;
      end
    end
    e.smp = 32'(bs - 1);
    e.stp = 32'(bst - 1);
    e.err = ((c / (2 * bs * bst)) > t);
    e.cyc = 32'((k + 2) * DIV_CYC);
    return e;
  endfunction

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk("R8", "done width", longint'(done), 0);
      if (busy) busy_cnt++;
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(tg, "sample_m1", longint'(sample_m1), longint'(e.smp));
          chk(tg, "step_m1",   longint'(step_m1),   longint'(e.stp));
          chk(tg, "too_fast",  longint'(too_fast),  longint'(e.err));
          chk(tg, "busy cycles (R7)", longint'(busy_cnt), longint'(e.cyc));
          chk("R8", "busy low at done", longint'(busy), 0);
          last_exp = e;
        end
        busy_cnt = 0;
        results_seen++;
      end
      done_prev = done;
    end
  end

  // Driver: pushes expectation, pulses start, waits for completion
  task automatic run(input longint c, input longint tg, input string tag);
    int seen;
    exp_q.push_back(model(c, tg));
    tag_q.push_back(tag);
    seen = results_seen;
    @(negedge clk);
    clk_src_hz = 32'(c);
    target_hz  = 32'(tg);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (results_seen == seen) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    clk_src_hz = '0;
    target_hz  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", longint'(busy), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "sample_m1", longint'(sample_m1), 0);
    chk("R1", "step_m1", longint'(step_m1), 0);
    chk("R1", "too_fast", longint'(too_fast), 0);

    run(1000000, 100000, "R7");       // exact hit at sample 1
    run(100000000, 100000, "R4");     // full sweep, best at sample 8
    run(26000000, 400000, "R4");
    run(100000000, 1000000, "R3");    // fast class limit 8
    run(100000000, 400000, "R3");     // boundary: limit 64
    run(100000000, 400001, "R5");     // limit 8, nothing fits, error set
    run(100000000, 5000000, "R2");    // clamped, exact at sample 3
    run(100000000, 3400000, "R2");
    run(100000000, 64'hFFFF_FFFF, "R2");
    run(200000000, 100, "R6");        // fallback pair and error flag
    run(1000, 0, "R10");              // zero target treated as 1 Hz
    run(100000000, 1000000, "R7");

    // R8: outputs hold while inputs change without start
    clk_src_hz = 32'd12345678;
    target_hz  = 32'd999;
    repeat (20) @(negedge clk);
    chk("R8", "hold sample_m1", longint'(sample_m1), longint'(last_exp.smp));
    chk("R8", "hold step_m1",   longint'(step_m1),   longint'(last_exp.stp));
    chk("R8", "hold too_fast",  longint'(too_fast),  longint'(last_exp.err));

    // R9: start while busy is ignored
    begin
      int seen;
      exp_q.push_back(model(1000000, 100000));
      tag_q.push_back("R9");
      seen = results_seen;
      @(negedge clk);
      clk_src_hz = 32'd1000000;
      target_hz  = 32'd100000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      clk_src_hz = 32'd200000000;
      target_hz  = 32'd100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (results_seen == seen) @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R9", "busy after ignored start", longint'(busy), 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule